// File: doc/BRIEF.md
# Logical-Operation Fetch and Execute Sequencer

This block is the control core of a very small accumulator machine that runs only the bitwise, compare, rotate and carry-control instructions. It fetches an opcode byte from a synchronous read port and decodes where the operand comes from: a general register, the byte addressed by the H:L pair, or an immediate byte that follows the opcode. When the operand is in memory it runs one more read cycle. It then passes the operand to the logic unit and writes the accumulator and the flags back. Each clock is one machine state. Register and accumulator-only forms take 4 states. Memory and immediate forms take 7.

The controller is a seven-state machine. `S_F1` drives the program counter onto the address bus with the read strobe, `S_F2` waits, and `S_F3` captures the opcode and steps the program counter. In `S_F4` the instruction is decoded. A short form executes there and goes back to `S_F1`. A form with a memory or immediate operand goes on to `S_R1` (address and strobe), then `S_R2` (wait), then `S_R3`. In `S_R3` the operand is sampled, the instruction executes, the program counter steps again for an immediate operand, and the machine returns to `S_F1`. The register file holds A, B, C, D, E, H and L. Its reset image is a parameter, all zero by default. There are no jumps, no stack, no interrupts, no memory writes and no arithmetic instructions.

Top module: `logic_op_sequencer`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the flags and the state counter, and loads every register from the reset-image parameter (slot k at bits 8k+7..8k, with B=0, C=1, D=2, E=3, H=4, L=5, A=7). While reset is held, no read strobe and no completion pulse are issued.
- R2: A register form takes 4 states and advances the program counter by one. Its opcode is 0xA0+r for AND, 0xA8+r for XOR, 0xB0+r for OR and 0xB8+r for compare, where r is the slot code above. The completion pulse is high in the fourth state.
- R3: A memory form uses r=6. It reads the byte at address {H,L}, with H as the high byte, in a second read cycle. It takes 7 states in total and advances the program counter by one only.
- R4: An immediate form (0xE6 AND, 0xEE XOR, 0xF6 OR, 0xFE compare) reads its operand from the byte after the opcode. It takes 7 states and advances the program counter by two.
- R5: AND writes its result to A. It sets AC to 1 and clears CY. S is result bit 7, Z is set when the result is zero, and P is set when the result has an even number of ones. The flag output is {S,Z,AC,P,CY}, with S at bit 4 and CY at bit 0.
- R6: OR and XOR write their result to A. They clear AC and CY, and set S, Z and P from the result as in R5.
- R7: Compare writes flags only. CY is set when A < operand and Z when A equals the operand. S and P come from A minus the operand, modulo 256. AC is set when the low nibble of A is below the low nibble of the operand. Neither A nor the operand source changes.
- R8: Rotates change A and CY only. 0x07 rotates left and copies bit 7 into bit 0 and into CY. 0x0F rotates right and copies bit 0 into bit 7 and into CY. 0x17 rotates left through CY. 0x1F rotates right through CY.
- R9: 0x2F inverts A and leaves all flags unchanged. 0x37 sets CY. 0x3F inverts CY. Each takes 4 states and leaves the other flags unchanged.
- R10: Any other opcode is a 4-state no-operation. It advances the program counter by one and changes neither A nor the flags.
- R11: The read strobe is high for exactly one state: the first state of each read cycle (state 1 of the fetch, and state 5 of a 7-state instruction). Data is taken in the third state of the cycle, so the memory must return it on the clock after the strobe and hold it.
- R12: The state counter increases by one on every clock out of reset. Between completions it therefore advances by the instruction lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one machine state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 8 | Read data from the synchronous memory |
| mem_addr | output | 16 | Read address (program counter or {H,L}) |
| mem_rd | output | 1 | Read strobe, first state of a read cycle |
| acc_o | output | 8 | Accumulator contents |
| flags_o | output | 5 | Flags {S,Z,AC,P,CY} |
| pc_o | output | 16 | Program counter |
| tstate_cnt | output | 32 | States elapsed since reset |
| instr_done | output | 1 | High in the final state of each instruction |

## Verification
The bench measures the length of every instruction and checks the position of the read strobe in every state. A design that adds an extra read for a register operand, or skips the read for a memory operand, gives the wrong length or a stray strobe. The operand address of the memory form must be {H,L}=0x20FF, and an immediate must come from the byte after its opcode. A swapped address byte or a missed program-counter step reads the wrong byte and produces a wrong accumulator. Compares are followed by an OR of the compared register into a cleared accumulator, so a compare that wrote anything becomes visible. Rotate sequences start from a set AC flag and a known CY, which exposes rotates through carry that use the wrong bit and rotates that disturb S, Z, AC or P.

// File: rtl/logic_seq_pkg.sv
package logic_seq_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 2 * BYTE_W;
    localparam int NIB_W     = BYTE_W / 2;
    localparam int SLOTS     = 8;
    localparam int SEL_W     = $clog2(SLOTS);
    localparam logic [SEL_W-1:0] SEL_H = 3'd4;
    localparam logic [SEL_W-1:0] SEL_L = 3'd5;
    localparam logic [SEL_W-1:0] SEL_M = 3'd6;
    localparam logic [SEL_W-1:0] SEL_A = 3'd7;

    typedef enum logic [3:0] {
        K_NOP, K_AND, K_XOR, K_OR, K_CMP,
        K_RLC, K_RRC, K_RAL, K_RAR, K_CMA, K_STC, K_CMC
    } kind_e;

    typedef enum logic [1:0] {SRC_NONE, SRC_REG, SRC_MEM, SRC_IMM} src_e;

    typedef struct packed {
        kind_e            kind;
        src_e             src;
        logic [SEL_W-1:0] sel;
    } dec_t;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;

    typedef enum logic [2:0] {S_F1, S_F2, S_F3, S_F4, S_R1, S_R2, S_R3} state_e;
endpackage

// File: rtl/lu_decode.sv
module lu_decode
    import logic_seq_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output dec_t              dec
);
    function automatic kind_e group_kind(input logic [1:0] g);
        unique case (g)
            2'b00:   return K_AND;
            2'b01:   return K_XOR;
            2'b10:   return K_OR;
            default: return K_CMP;
        endcase
    endfunction

    always_comb begin
        dec.kind = K_NOP;
        dec.src  = SRC_NONE;
        dec.sel  = opcode[2:0];
        if (opcode[7:5] == 3'b101) begin
            dec.kind = group_kind(opcode[4:3]);
            dec.src  = (opcode[2:0] == SEL_M) ? SRC_MEM : SRC_REG;
        end else if (opcode[7:5] == 3'b111 && opcode[2:0] == 3'b110) begin
            dec.kind = group_kind(opcode[4:3]);
            dec.src  = SRC_IMM;
        end else if (opcode[7:6] == 2'b00 && opcode[2:0] == 3'b111) begin
            unique case (opcode[5:3])
                3'd0:    dec.kind = K_RLC;
                3'd1:    dec.kind = K_RRC;
                3'd2:    dec.kind = K_RAL;
                3'd3:    dec.kind = K_RAR;
                3'd5:    dec.kind = K_CMA;
                3'd6:    dec.kind = K_STC;
                3'd7:    dec.kind = K_CMC;
                default: dec.kind = K_NOP;
            endcase
        end
    end
endmodule

// File: rtl/lu_alu.sv
module lu_alu
    import logic_seq_pkg::*;
(
    input  kind_e             kind,
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    input  flags_t            f_in,
    output logic [BYTE_W-1:0] res,
    output logic              acc_we,
    output flags_t            f_out
);
    logic [BYTE_W:0] diff;
    assign diff = {1'b0, a} - {1'b0, b};

    function automatic flags_t bit_flags(input logic [BYTE_W-1:0] r, input logic ac);
        return '{s: r[BYTE_W-1], z: (r == '0), ac: ac, p: ~^r, cy: 1'b0};
    endfunction

    always_comb begin
        res    = a;
        acc_we = 1'b0;
        f_out  = f_in;
        unique case (kind)
            K_AND: begin res = a & b; acc_we = 1'b1; f_out = bit_flags(a & b, 1'b1); end
            K_XOR: begin res = a ^ b; acc_we = 1'b1; f_out = bit_flags(a ^ b, 1'b0); end
            K_OR:  begin res = a | b; acc_we = 1'b1; f_out = bit_flags(a | b, 1'b0); end
            K_CMP: f_out = '{s: diff[BYTE_W-1], z: (a == b), ac: (a[NIB_W-1:0] < b[NIB_W-1:0]),
                             p: ~^diff[BYTE_W-1:0], cy: diff[BYTE_W]};
            K_RLC: begin res = {a[BYTE_W-2:0], a[BYTE_W-1]}; acc_we = 1'b1; f_out.cy = a[BYTE_W-1]; end
            K_RRC: begin res = {a[0], a[BYTE_W-1:1]};        acc_we = 1'b1; f_out.cy = a[0]; end
            K_RAL: begin res = {a[BYTE_W-2:0], f_in.cy};     acc_we = 1'b1; f_out.cy = a[BYTE_W-1]; end
            K_RAR: begin res = {f_in.cy, a[BYTE_W-1:1]};     acc_we = 1'b1; f_out.cy = a[0]; end
            K_CMA: begin res = ~a; acc_we = 1'b1; end
            K_STC: f_out.cy = 1'b1;
            K_CMC: f_out.cy = ~f_in.cy;
            default: ;
        endcase
    end
endmodule

// File: rtl/lu_regfile.sv
module lu_regfile
    import logic_seq_pkg::*;
#(
    parameter logic [SLOTS*BYTE_W-1:0] RESET_IMAGE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic              acc_we,
    input  logic [BYTE_W-1:0] acc_wdata,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] acc,
    output logic [BYTE_W-1:0] h_reg,
    output logic [BYTE_W-1:0] l_reg
);
    logic [BYTE_W-1:0] slot [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i == int'(SEL_M)) begin : g_hole
            assign slot[i] = '0;
        end else if (i == int'(SEL_A)) begin : g_acc
            always_ff @(posedge clk) begin
                if (rst)         slot[i] <= RESET_IMAGE[i*BYTE_W +: BYTE_W];
                else if (acc_we) slot[i] <= acc_wdata;
            end
        end else begin : g_gpr
            always_ff @(posedge clk) begin
                if (rst) slot[i] <= RESET_IMAGE[i*BYTE_W +: BYTE_W];
            end
        end
    end

    assign rd_data = slot[rd_sel];
    assign acc     = slot[SEL_A];
    assign h_reg   = slot[SEL_H];
    assign l_reg   = slot[SEL_L];
endmodule

// File: rtl/logic_op_sequencer.sv
module logic_op_sequencer
    import logic_seq_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter logic [SLOTS*BYTE_W-1:0] RESET_IMAGE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic [BYTE_W-1:0] acc_o,
    output logic [4:0]        flags_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [CNT_W-1:0]  tstate_cnt,
    output logic              instr_done
);
    state_e            state_q, state_d;
    logic [ADDR_W-1:0] pc_q;
    logic [BYTE_W-1:0] opcode_q;
    flags_t            flags_q, alu_flags;
    logic [CNT_W-1:0]  cnt_q;
    dec_t              dec;
    logic [BYTE_W-1:0] rf_rd, acc, h_reg, l_reg, operand, alu_res;
    logic              alu_we, short_form;

    lu_decode u_decode (.opcode(opcode_q), .dec(dec));

    lu_regfile #(.RESET_IMAGE(RESET_IMAGE)) u_regfile (
        .clk(clk), .rst(rst), .rd_sel(dec.sel),
        .acc_we(alu_we && instr_done), .acc_wdata(alu_res),
        .rd_data(rf_rd), .acc(acc), .h_reg(h_reg), .l_reg(l_reg)
    );

    assign operand = (dec.src == SRC_REG) ? rf_rd : mem_rdata;

    lu_alu u_alu (
        .kind(dec.kind), .a(acc), .b(operand), .f_in(flags_q),
        .res(alu_res), .acc_we(alu_we), .f_out(alu_flags)
    );

    assign short_form = (dec.src == SRC_NONE) || (dec.src == SRC_REG);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_F1: state_d = S_F2;
            S_F2: state_d = S_F3;
            S_F3: state_d = S_F4;
            S_F4: state_d = short_form ? S_F1 : S_R1;
            S_R1: state_d = S_R2;
            S_R2: state_d = S_R3;
            S_R3: state_d = S_F1;
            default: state_d = S_F1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_F1;
            pc_q     <= '0;
            opcode_q <= '0;
            flags_q  <= '0;
            cnt_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_q + 1'b1;
            if (state_q == S_F3) begin
                opcode_q <= mem_rdata;
                pc_q     <= pc_q + 1'b1;
            end
            if (state_q == S_R3 && dec.src == SRC_IMM) pc_q <= pc_q + 1'b1;
            if (instr_done) flags_q <= alu_flags;
        end
    end

    always_comb begin
        mem_rd     = 1'b0;
        mem_addr   = pc_q;
        instr_done = 1'b0;
        unique case (state_q)
            S_F1: mem_rd = !rst;
            S_F4: instr_done = short_form && !rst;
            S_R1: begin
                mem_rd = !rst;
                if (dec.src == SRC_MEM) mem_addr = {h_reg, l_reg};
            end
            S_R3: instr_done = !rst;
            default: ;
        endcase
    end

    assign acc_o      = acc;
    assign flags_o    = flags_q;
    assign pc_o       = pc_q;
    assign tstate_cnt = cnt_q;

    // checker: position of the current state inside its instruction
    logic [2:0] pos_q;
    always_ff @(posedge clk) begin
        if (rst || state_d == S_F1) pos_q <= 3'd1;
        else                        pos_q <= pos_q + 3'd1;
    end

    p_strobe_single_r11: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);
    p_short_len_r2: assert property (@(posedge clk) disable iff (rst)
        (instr_done && short_form) |-> (pos_q == 3'd4));
    p_long_len_r4: assert property (@(posedge clk) disable iff (rst)
        (instr_done && !short_form) |-> (pos_q == 3'd7));
    p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_F3) |=> (pc_q == $past(pc_q) + 1'b1));
    p_cmp_keeps_acc_r7: assert property (@(posedge clk) disable iff (rst)
        (instr_done && dec.kind == K_CMP) |=> $stable(acc_o));
    p_rot_flags_r8: assert property (@(posedge clk) disable iff (rst)
        (instr_done && (dec.kind == K_RLC || dec.kind == K_RRC ||
                        dec.kind == K_RAL || dec.kind == K_RAR)) |=> $stable(flags_o[4:1]));
endmodule

// File: tb/logic_op_sequencer_bench.sv
`timescale 1ns/1ps
module logic_op_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  acc_o;
    logic [4:0]  flags_o;
    logic [15:0] pc_o;
    logic [31:0] tstate_cnt;
    logic        instr_done;

    // slots: B=82 C=B5 D=06 E=0F H=20 L=FF (slot6 unused) A=65
    localparam logic [63:0] IMAGE = 64'h65_00_FF_20_0F_06_B5_82;

    logic_op_sequencer #(.CNT_W(32), .RESET_IMAGE(IMAGE)) u_logic_op_sequencer (
        .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .acc_o(acc_o), .flags_o(flags_o), .pc_o(pc_o),
        .tstate_cnt(tstate_cnt), .instr_done(instr_done)
    );

    always #2 clk = ~clk;

    logic [7:0] prog [256];
    int checks = 0;
    int fails = 0;
    logic [15:0] pc_model;
    int tsum;

    always @(posedge clk) begin
        if (mem_rd) begin
            if (mem_addr[15:8] == 8'h00) mem_rdata <= prog[mem_addr[7:0]];
            else if (mem_addr == 16'h20FF) mem_rdata <= 8'hEF;
            else mem_rdata <= 8'h00;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1 rst = 1'b0;
        pc_model = 16'h0000;
        tsum = 0;
    endtask

    task automatic exec(input string req, input int exp_len, input logic [15:0] op_addr,
                        input logic [7:0] exp_acc, input logic [4:0] exp_flags, input logic [15:0] exp_pc);
        int n = 0;
        bit got = 0;
        while (!got && n < 20) begin
            @(negedge clk);
            n++;
            chk("R11", "strobe", 32'(mem_rd), 32'((n == 1) || (n == 5)));
            if (n == 1) chk(req, "fetch addr", 32'(mem_addr), 32'(pc_model));
            if (n == 5) chk(req, "operand addr", 32'(mem_addr), 32'(op_addr));
            if (instr_done) got = 1;
        end
        chk(req, "length", 32'(n), 32'(exp_len));
        @(posedge clk);
        #1;
        chk(req, "acc", 32'(acc_o), 32'(exp_acc));
        chk(req, "flags", 32'(flags_o), 32'(exp_flags));
        chk(req, "pc", 32'(pc_o), 32'(exp_pc));
        tsum += exp_len;
        chk("R12", "state count", tstate_cnt, 32'(tsum));
        pc_model = exp_pc;
    endtask

    task automatic t_reset();
        clear_prog();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "acc image", 32'(acc_o), 32'h65);
        chk("R1", "flags", 32'(flags_o), 32'h0);
        chk("R1", "pc", 32'(pc_o), 32'h0);
        chk("R1", "count", tstate_cnt, 32'h0);
        chk("R1", "strobe", 32'(mem_rd), 32'h0);
        chk("R1", "done", 32'(instr_done), 32'h0);
    endtask

    task automatic t_register_forms();
        clear_prog();
        prog[0] = 8'hA0; prog[1] = 8'hB1; prog[2] = 8'hAA; prog[3] = 8'hAF;
        do_reset();
        exec("R2 R5", 4, 16'h0, 8'h00, 5'b01110, 16'd1);
        exec("R2 R6", 4, 16'h0, 8'hB5, 5'b10000, 16'd2);
        exec("R2 R6", 4, 16'h0, 8'hB3, 5'b10000, 16'd3);
        exec("R2 R6", 4, 16'h0, 8'h00, 5'b01010, 16'd4);
    endtask

    task automatic t_memory_forms();
        clear_prog();
        prog[0] = 8'hA6; prog[1] = 8'hB6;
        do_reset();
        exec("R3 R5", 7, 16'h20FF, 8'h65, 5'b00110, 16'd1);
        exec("R3 R6", 7, 16'h20FF, 8'hEF, 5'b10000, 16'd2);
    endtask

    task automatic t_immediate_forms();
        clear_prog();
        prog[0] = 8'hE6; prog[1] = 8'h0F; prog[2] = 8'hEE; prog[3] = 8'h2F;
        prog[4] = 8'hF6; prog[5] = 8'h80;
        do_reset();
        exec("R4 R5", 7, 16'd1, 8'h05, 5'b00110, 16'd2);
        exec("R4 R6", 7, 16'd3, 8'h2A, 5'b00000, 16'd4);
        exec("R4 R6", 7, 16'd5, 8'hAA, 5'b10010, 16'd6);
    endtask

    task automatic t_compare();
        clear_prog();
        prog[0] = 8'hB8; prog[1] = 8'hFE; prog[2] = 8'h65; prog[3] = 8'hBB;
        prog[4] = 8'hBE; prog[5] = 8'hAF; prog[6] = 8'hB0;
        do_reset();
        exec("R7", 4, 16'h0,    8'h65, 5'b10001, 16'd1);
        exec("R7", 7, 16'd2,    8'h65, 5'b01010, 16'd3);
        exec("R7", 4, 16'h0,    8'h65, 5'b00110, 16'd4);
        exec("R7", 7, 16'h20FF, 8'h65, 5'b00101, 16'd5);
        exec("R6", 4, 16'h0,    8'h00, 5'b01010, 16'd6);
        exec("R7", 4, 16'h0,    8'h82, 5'b10010, 16'd7);
    endtask

    task automatic t_rotate_carry();
        clear_prog();
        prog[0] = 8'hA2; prog[1] = 8'h37; prog[2] = 8'h17; prog[3] = 8'h07;
        prog[4] = 8'h0F; prog[5] = 8'h0F; prog[6] = 8'h1F; prog[7] = 8'h3F;
        prog[8] = 8'h2F; prog[9] = 8'h37; prog[10] = 8'h3F;
        do_reset();
        exec("R5", 4, 16'h0, 8'h04, 5'b00100, 16'd1);
        exec("R9", 4, 16'h0, 8'h04, 5'b00101, 16'd2);
        exec("R8", 4, 16'h0, 8'h09, 5'b00100, 16'd3);
        exec("R8", 4, 16'h0, 8'h12, 5'b00100, 16'd4);
        exec("R8", 4, 16'h0, 8'h09, 5'b00100, 16'd5);
        exec("R8", 4, 16'h0, 8'h84, 5'b00101, 16'd6);
        exec("R8", 4, 16'h0, 8'hC2, 5'b00100, 16'd7);
        exec("R9", 4, 16'h0, 8'hC2, 5'b00101, 16'd8);
        exec("R9", 4, 16'h0, 8'h3D, 5'b00101, 16'd9);
        exec("R9", 4, 16'h0, 8'h3D, 5'b00101, 16'd10);
        exec("R9", 4, 16'h0, 8'h3D, 5'b00100, 16'd11);
    endtask

    task automatic t_unknown();
        clear_prog();
        prog[0] = 8'h00; prog[1] = 8'hC3; prog[2] = 8'h27;
        do_reset();
        exec("R10", 4, 16'h0, 8'h65, 5'b00000, 16'd1);
        exec("R10", 4, 16'h0, 8'h65, 5'b00000, 16'd2);
        exec("R10", 4, 16'h0, 8'h65, 5'b00000, 16'd3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_register_forms();
        t_memory_forms();
        t_immediate_forms();
        t_compare();
        t_rotate_carry();
        t_unknown();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule